// File: doc/BRIEF.md
# Lane-Split Linear Congruential Hash Engine

This block computes a 32-bit universal hash of a message against a key of the same length in words. It does not use one 32-bit multiply-accumulate path with a 64-bit accumulator. Instead it cuts every 32-bit input word into equal slices and gives each slice to its own narrow lane. Each lane multiplies its message slice by the matching key slice, adds the product to a running sum, and reduces that sum modulo a prime just below two to the lane width. The 32-bit result is the lane residues placed side by side. The lane width is a parameter and may be 32, 16 or 8 bits, which gives one, two or four lanes.

A message enters one word per clock. On each transfer the message word and the key word arrive together, with flags that mark the first word and the final word. One clock after the final word, the engine shows the finished hash and pulses a valid flag. A new message may start in that same clock, with no gap between messages.

Top module: `lch_split_hash`

## Requirements
- R1: While reset is held and in the first cycle after it, `hash_valid` is 0 and `hash` is 0.
- R2: Lane j takes bits [j*W +: W] of both `msg_word` and `key_word`, and its residue appears at bits [j*W +: W] of `hash`. W is the lane width.
- R3: The residue of each lane equals the sum of (message slice × key slice) over all words from the word with `in_start` through the word with `in_last`, modulo that lane's prime.
- R4: A word with `in_start` discards all earlier accumulation, so that word's product is the first term of a new sum.
- R5: `hash_valid` is 1 in exactly the cycle after a transfer with `in_last`, and 0 in every other cycle.
- R6: A single-word message, with `in_start` and `in_last` both high on one transfer, yields that one product modulo the prime.
- R7: Every lane residue held in `hash` is always strictly below that lane's prime.
- R8: While `in_valid` is low, the message, key and flag inputs have no effect: `hash` holds its value.
- R9: In the cycle where `hash_valid` is high, `hash` shows the completed result even if the first word of the next message is transferred in that same cycle.
- R10: The lane prime is 251 for W=8, 65521 for W=16 and 4294967291 for W=32.
- R11: The engine accepts one 32-bit word every clock with no stall, including across back-to-back messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A word transfer takes place this cycle |
| in_start | input | 1 | This word is the first of a message |
| in_last | input | 1 | This word is the final word of a message |
| msg_word | input | 32 | Message word |
| key_word | input | 32 | Key word matching this message word |
| hash_valid | output | 1 | One-cycle pulse: `hash` holds a finished result |
| hash | output | 32 | Lane residues placed side by side |

## Verification
Two things can happen in one cycle. A message can begin and end on the same word, and a finished result can be presented in the very cycle the next message's first word is taken. The bench produces the first case by sweeping every 8-bit slice value through single-word messages. It produces the second by sending messages back to back with no idle cycle between them. In each case it samples `hash` in the `hash_valid` cycle and compares it with the per-lane sum-of-products computed in 64-bit integers, so a result corrupted by the incoming word shows up at once. Two instances, one with 8-bit lanes and one with 16-bit lanes, receive identical stimulus.

// File: rtl/lch_split_hash_pkg.sv
package lch_split_hash_pkg;

    localparam int HASH_W = 32;

    // One input transfer as seen by the lanes
    typedef struct packed {
        logic              start;
        logic              last;
        logic [HASH_W-1:0] msg;
        logic [HASH_W-1:0] key;
    } beat_t;

    // Largest prime below 2^w for each supported lane width (R10)
    function automatic longint unsigned lane_prime(int w);
        case (w)
            8:       return 64'd251;
            16:      return 64'd65521;
            default: return 64'd4294967291;
        endcase
    endfunction

endpackage

// File: rtl/lch_lane.sv
module lch_lane #(
    parameter int              W = 16,
    parameter longint unsigned P = 64'd65521
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         clear,
    input  logic [W-1:0] m,
    input  logic [W-1:0] x,
    output logic [W-1:0] acc_o
);
    localparam int SUM_W = 2 * W + 1;

    logic [W-1:0]     acc_q;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;
    logic [W-1:0]     acc_d;

    // Reduce every cycle so the held residue stays below the prime
    always_comb begin
        base  = clear ? '0 : SUM_W'(acc_q);
        sum   = base + SUM_W'(m) * SUM_W'(x);
        acc_d = W'(sum % SUM_W'(P));
    end

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (load) acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    // R7: held residue never reaches the prime
    a_r7_below_prime: assert property (@(posedge clk) disable iff (rst)
        SUM_W'(acc_q) < SUM_W'(P));

    // R8: without a transfer the residue does not move
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(acc_q));

    // R4: a fresh message whose first product is zero starts from zero
    a_r4_clear_restart: assert property (@(posedge clk) disable iff (rst)
        (load && clear && (m == '0)) |=> (acc_q == '0));

endmodule

// File: rtl/lch_done_ctrl.sv
module lch_done_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_last,
    output logic hash_valid
);
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= in_valid & in_last;
    end

    assign hash_valid = done_q;

    // R5: a final word is always followed by the valid pulse
    a_r5_valid_follows_last: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> hash_valid);

    // R5: no pulse without a final word in the cycle before
    a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> !hash_valid);

endmodule

// File: rtl/lch_split_hash.sv
module lch_split_hash
    import lch_split_hash_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic              in_last,
    input  logic [HASH_W-1:0] msg_word,
    input  logic [HASH_W-1:0] key_word,
    output logic              hash_valid,
    output logic [HASH_W-1:0] hash
);
    localparam int              N_LANES = HASH_W / LANE_W;
    localparam longint unsigned PRIME   = lane_prime(LANE_W);

    beat_t beat;
    assign beat = '{start: in_start, last: in_last, msg: msg_word, key: key_word};

    // R2: slice j of each word feeds lane j; residue j fills slice j of hash
    for (genvar j = 0; j < N_LANES; j++) begin : g_lane
        lch_lane #(.W(LANE_W), .P(PRIME)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .load  (in_valid),
            .clear (beat.start),
            .m     (beat.msg[j*LANE_W +: LANE_W]),
            .x     (beat.key[j*LANE_W +: LANE_W]),
            .acc_o (hash[j*LANE_W +: LANE_W])
        );
    end

    lch_done_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_last    (beat.last),
        .hash_valid (hash_valid)
    );

    // R1: the first cycle after reset shows nothing finished
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!hash_valid && hash == '0));

endmodule

// File: tb/lch_split_hash_tb.sv
module lch_split_hash_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_start, in_last;
    logic [31:0] msg_word, key_word;
    logic        hv8, hv16;
    logic [31:0] h8, h16;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [31:0] mw [16];
    logic [31:0] kw [16];

    always #2.5 clk = ~clk;

    lch_split_hash #(.LANE_W(8)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .msg_word(msg_word), .key_word(key_word),
        .hash_valid(hv8), .hash(h8));

    lch_split_hash #(.LANE_W(16)) u_dut_w16 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .msg_word(msg_word), .key_word(key_word),
        .hash_valid(hv16), .hash(h16));

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            report();
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model: plain sum of products per slice, reduced once (R3, R10)
    function automatic logic [31:0] ref_hash(int lw, int n);
        longint unsigned p    = (lw == 8) ? 64'd251 : 64'd65521;
        longint unsigned mask = (64'd1 << lw) - 1;
        logic [31:0]     r    = '0;
        for (int j = 0; j < 32 / lw; j++) begin
            longint unsigned s = 0;
            for (int i = 0; i < n; i++) begin
                longint unsigned mc = (64'(mw[i]) >> (j * lw)) & mask;
                longint unsigned kc = (64'(kw[i]) >> (j * lw)) & mask;
                s += mc * kc;
            end
            r |= 32'((s % p) << (j * lw));
        end
        return r;
    endfunction

    // Drive from a falling edge; returns at the falling edge after the final word
    task automatic send(int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_start = (i == 0);
            in_last  = (i == n - 1);
            msg_word = mw[i];
            key_word = kw[i];
            @(negedge clk);
        end
    endtask

    task automatic idle_garbage(logic [31:0] g);
        in_valid = 1'b0; in_start = 1'b1; in_last = 1'b1;
        msg_word = g; key_word = ~g;
        @(negedge clk);
    endtask

    task automatic check_done(string req, logic [31:0] e8, logic [31:0] e16);
        check({req, " valid w8"}, 32'(hv8), 32'd1);
        check({req, " valid w16"}, 32'(hv16), 32'd1);
        check({req, " hash w8"}, h8, e8);
        check({req, " hash w16"}, h16, e16);
    endtask

    initial begin
        logic [31:0] e8, e16, p8, p16;
        rst = 1'b1; in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
        msg_word = '0; key_word = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {30'd0, hv16, hv8}, 32'd0);
        check("R1 hash w8", h8, 32'd0);
        check("R1 hash w16", h16, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {30'd0, hv16, hv8}, 32'd0);

        // R6, R2, R10: single-word sweep over every 8-bit slice value
        for (int a = 0; a < 256; a++) begin
            logic [7:0] b = 8'(a);
            mw[0] = {b, ~b, b ^ 8'h3C, 8'(b * 7)};
            kw[0] = {8'hFF, b, 8'h01, 8'(~b * 3)};
            e8 = ref_hash(8, 1); e16 = ref_hash(16, 1);
            send(1);
            check_done("R6 single word", e8, e16);
            idle_garbage(32'hDEAD_0000 + 32'(a));
        end

        // R3, R4, R9, R11: back-to-back messages of growing length
        p8 = '0; p16 = '0;
        for (int n = 1; n <= 16; n++) begin
            for (int i = 0; i < n; i++) begin
                mw[i] = 32'h9E37_79B9 * 32'(n * 17 + i + 1);
                kw[i] = 32'h85EB_CA6B ^ (32'(i) << (n % 24));
            end
            e8 = ref_hash(8, n); e16 = ref_hash(16, n);
            if (n > 1) begin
                // previous result must still be shown while this message starts (R9)
                check_done("R9 overlap", p8, p16);
            end
            send(n);
            p8 = e8; p16 = e16;
        end
        check_done("R3 R11 back-to-back", p8, p16);

        // R8, R5: idle cycles with toggling inputs leave hash alone, valid drops
        for (int g = 0; g < 4; g++) begin
            idle_garbage(32'hA5A5_0F0F << g);
            check("R5 valid low w8", 32'(hv8), 32'd0);
            check("R5 valid low w16", 32'(hv16), 32'd0);
            check("R8 hold w8", h8, p8);
            check("R8 hold w16", h16, p16);
        end

        // R7: all-ones words, longest message, largest residues
        for (int i = 0; i < 16; i++) begin mw[i] = '1; kw[i] = '1; end
        e8 = ref_hash(8, 16); e16 = ref_hash(16, 16);
        send(16);
        check_done("R7 all ones", e8, e16);

        // R4: a new start after a partial message discards the partial sum
        mw[0] = 32'h1234_5678; kw[0] = 32'h0F0F_F0F0;
        in_valid = 1'b1; in_start = 1'b1; in_last = 1'b0;
        msg_word = 32'hFFFF_FFFF; key_word = 32'hFFFF_FFFF;
        @(negedge clk);
        e8 = ref_hash(8, 1); e16 = ref_hash(16, 1);
        send(1);
        check_done("R4 restart", e8, e16);
        idle_garbage(32'h0);

        report();
    end

endmodule